// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

This block sits between a set of interrupt sources and a CPU core. Sixteen request lines are folded onto nine vectors by OR-ing the sources that share a vector. Each vector has an enable bit and a one-bit level select. The level select puts the vector either in the low class or in its upper class. For the first two vectors the upper class is the top level; for the other seven it is the middle level. Among the enabled, pending vectors the arbiter picks one winner. It raises an interrupt request toward the CPU only when that winner outranks the level now being serviced. It also presents the winner's vector address.

When the CPU takes the interrupt it pulses an acknowledge strobe. The arbiter then saves the level being serviced on a small internal stack and adopts the winner's level. A return strobe restores the saved level, so handlers can nest up to three deep. The CPU's own sequencing, and the clearing of source flags, are left to the CPU.

Top module: `nest_irq_arbiter`

## Requirements
- R1: While reset is held and right after it, the current level is none (code 0), no interrupt is requested, and the vector address reads 0.
- R2: A vector is pending when any of its sources is pending. The sources map to vectors as follows: 0,1→0; 2→1; 3..6→2; 7,8→3; 9,10→4; 11,12→5; 13→6; 14→7; 15→8.
- R3: A vector whose enable bit is clear never takes part in arbitration, whatever its sources do.
- R4: Levels are coded none=0, low=1, high=2, highest=3. A clear level-select bit gives low. A set bit gives highest for vectors 0 and 1, and high for vectors 2 to 8.
- R5: The winner is the pending, enabled vector with the greatest level; a tie goes to the lower vector index. Vector index i has address 8*i+3, so the addresses run 03h through 43h.
- R6: The interrupt request is high only when the winner's level is strictly above the current level. The vector address is the winner's address while the request is high, and 0 otherwise.
- R7: An acknowledge while the request is high saves the current level. From the next cycle on, the current level equals the winner's level at the time of the acknowledge.
- R8: An acknowledge while the request is low changes nothing.
- R9: A return restores the most recently saved level on the next cycle. A return with nothing saved changes nothing, and the level stays none.
- R10: When acknowledge and return arrive in the same cycle, the return is carried out and the acknowledge is ignored.
- R11: Nesting from none through low and high to highest is held three deep, and successive returns retrace the levels in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | 16 | Pending flags of the individual sources |
| vec_en | input | 9 | Per-vector enable |
| lvl_hi | input | 9 | Per-vector level select (1 = upper class, 0 = low) |
| ack_i | input | 1 | CPU acknowledges the offered interrupt |
| reti_i | input | 1 | CPU returns from the current handler |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_addr_o | output | 8 | Address of the winning vector |
| cur_lvl_o | output | 2 | Level now being serviced |

## Verification
The bench targets several corner cases and the failure each would expose:
- Equal-level ties: a picker that favoured the higher index would report 0Bh or 2Bh where 03h or 23h is due.
- A same-level request during a handler: a design comparing with greater-or-equal would nest a handler inside one of its own level.
- A return with an empty stack, and an acknowledge coinciding with a return: a bad design would underflow and invent a level, or push and pop together.
- Disabled vectors carrying requests, and the highest level placed on vectors 0 and 1 only: these catch a mask applied after the pick, or a level map applied to the wrong vectors.

A long random phase then mixes all of these while nesting runs its full three-deep depth.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_TOP  = 2'd3
    } lvl_e;

    localparam int unsigned LVL_W = 2;

endpackage

// File: rtl/irq_src_merge.sv
module irq_src_merge #(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned NUM_VEC = 9,
    parameter int unsigned SRC_VEC [NUM_SRC] = '{default: 0}
) (
    input  logic [NUM_SRC-1:0] src_req,
    output logic [NUM_VEC-1:0] vec_req
);

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (SRC_VEC[s] == v) begin
                    hit = hit | src_req[s];
                end
            end
        end
        assign vec_req[v] = hit;
    end

endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_VEC = 9,
    parameter int unsigned TOP_VECS = 2
) (
    input  logic [NUM_VEC-1:0]            vec_req,
    input  logic [NUM_VEC-1:0]            vec_en,
    input  logic [NUM_VEC-1:0]            lvl_hi,
    output logic [NUM_VEC-1:0][LVL_W-1:0] vec_lvl
);

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_map
        localparam lvl_e UPPER = (v < TOP_VECS) ? LVL_TOP : LVL_HIGH;
        always_comb begin
            if (!(vec_req[v] && vec_en[v])) begin
                vec_lvl[v] = LVL_NONE;
            end else if (lvl_hi[v]) begin
                vec_lvl[v] = UPPER;
            end else begin
                vec_lvl[v] = LVL_LOW;
            end
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_VEC = 9,
    localparam int unsigned IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic [NUM_VEC-1:0][LVL_W-1:0] vec_lvl,
    output logic [LVL_W-1:0]              win_lvl,
    output logic [IDX_W-1:0]              win_idx
);

    // Single pass from index 0 upward; strict comparison keeps the lowest
    // index among equals.
    always_comb begin
        win_lvl = LVL_NONE;
        win_idx = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (vec_lvl[i] > win_lvl) begin
                win_lvl = vec_lvl[i];
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
    import irq_arb_pkg::*;
#(
    parameter int unsigned DEPTH = 3,
    localparam int unsigned PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] din,
    output logic [LVL_W-1:0] dout,
    output logic             empty,
    output logic             full
);

    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][LVL_W-1:0] mem;
        logic [PTR_W-1:0]            ptr;
    } stk_t;

    stk_t stk_d, stk_q;

    assign empty = (stk_q.ptr == '0);
    assign full  = (stk_q.ptr == FULL_CNT);
    assign dout  = empty ? LVL_NONE : stk_q.mem[PTR_W'(stk_q.ptr - 1'b1)];

    always_comb begin
        stk_d = stk_q;
        if (pop && !empty) begin
            stk_d.ptr = stk_q.ptr - 1'b1;
        end else if (push && !full) begin
            stk_d.mem[stk_q.ptr] = din;
            stk_d.ptr            = stk_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    // R11: nesting never asks for more slots than the stack holds
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> !full);

    // R9: a pop on an empty stack leaves it empty
    assert_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> empty);

endmodule

// File: rtl/nest_irq_arbiter.sv
module nest_irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 16,
    parameter int unsigned NUM_VEC   = 9,
    parameter int unsigned TOP_VECS  = 2,
    parameter int unsigned DEPTH     = 3,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned VEC_BASE  = 3,
    parameter int unsigned VEC_STEP  = 8,
    parameter int unsigned SRC_VEC [NUM_SRC] =
        '{0, 0, 1, 2, 2, 2, 2, 3, 3, 4, 4, 5, 5, 6, 7, 8}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_VEC-1:0] vec_en,
    input  logic [NUM_VEC-1:0] lvl_hi,
    input  logic               ack_i,
    input  logic               reti_i,
    output logic               irq_o,
    output logic [ADDR_W-1:0]  vec_addr_o,
    output logic [LVL_W-1:0]   cur_lvl_o
);

    localparam int unsigned IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    typedef struct packed {
        logic [LVL_W-1:0] cur;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [NUM_VEC-1:0]            vec_req;
    logic [NUM_VEC-1:0][LVL_W-1:0] vec_lvl;
    logic [LVL_W-1:0]              win_lvl;
    logic [IDX_W-1:0]              win_idx;
    logic                          stk_push, stk_pop;
    logic [LVL_W-1:0]              stk_top;
    logic                          stk_empty, stk_full;

    irq_src_merge #(
        .NUM_SRC (NUM_SRC),
        .NUM_VEC (NUM_VEC),
        .SRC_VEC (SRC_VEC)
    ) u_merge (
        .src_req (src_req),
        .vec_req (vec_req)
    );

    irq_level_map #(
        .NUM_VEC  (NUM_VEC),
        .TOP_VECS (TOP_VECS)
    ) u_map (
        .vec_req (vec_req),
        .vec_en  (vec_en),
        .lvl_hi  (lvl_hi),
        .vec_lvl (vec_lvl)
    );

    irq_prio_pick #(
        .NUM_VEC (NUM_VEC)
    ) u_pick (
        .vec_lvl (vec_lvl),
        .win_lvl (win_lvl),
        .win_idx (win_idx)
    );

    irq_lvl_stack #(
        .DEPTH (DEPTH)
    ) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stk_push),
        .pop   (stk_pop),
        .din   (st_q.cur),
        .dout  (stk_top),
        .empty (stk_empty),
        .full  (stk_full)
    );

    assign irq_o      = (win_lvl > st_q.cur);
    assign vec_addr_o = irq_o ? ADDR_W'(VEC_BASE + VEC_STEP * int'(win_idx)) : '0;
    assign cur_lvl_o  = st_q.cur;

    always_comb begin
        st_d     = st_q;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        if (reti_i) begin
            if (!stk_empty) begin
                stk_pop  = 1'b1;
                st_d.cur = stk_top;
            end
        end else if (ack_i && irq_o) begin
            stk_push = 1'b1;
            st_d.cur = win_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cur: LVL_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    // R7: an accepted acknowledge raises the level being serviced
    assert_ack_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !reti_i) |=> (cur_lvl_o > $past(cur_lvl_o)));

    // R8: an acknowledge with nothing offered leaves the level alone
    assert_ack_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o && !reti_i) |=> $stable(cur_lvl_o));

    // R9: a return from a handler lowers the level
    assert_reti_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && cur_lvl_o != LVL_NONE) |=> (cur_lvl_o < $past(cur_lvl_o)));

    // R3: the offered vector is always an enabled one
    assert_win_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> vec_en[win_idx]);

    // R4: the top level only ever comes from the first vectors
    assert_top_vecs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && win_lvl == LVL_TOP) |-> (int'(win_idx) < TOP_VECS));

    // R11: level none and an empty stack go together
    assert_none_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_lvl_o == LVL_NONE) == stk_empty);

endmodule

// File: tb/sim_nest_irq_arbiter.sv
module sim_nest_irq_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_req = '0;
    logic [8:0]  vec_en = '0;
    logic [8:0]  lvl_hi = '0;
    logic        ack_i = 1'b0;
    logic        reti_i = 1'b0;
    logic        irq_o;
    logic [7:0]  vec_addr_o;
    logic [1:0]  cur_lvl_o;

    int errors = 0;
    int checks = 0;
    string tag = "R1";

    int src_map [16] = '{0, 0, 1, 2, 2, 2, 2, 3, 3, 4, 4, 5, 5, 6, 7, 8};
    int model_lvl = 0;
    int model_stk [$];

    always #2 clk = ~clk;

    nest_irq_arbiter u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_req    (src_req),
        .vec_en     (vec_en),
        .lvl_hi     (lvl_hi),
        .ack_i      (ack_i),
        .reti_i     (reti_i),
        .irq_o      (irq_o),
        .vec_addr_o (vec_addr_o),
        .cur_lvl_o  (cur_lvl_o)
    );

    // Behavioural winner: scan levels from the top down, vectors from 0 up.
    function automatic void pick(output int wl, output int wi);
        wl = 0;
        wi = 0;
        for (int l = 3; l >= 1 && wl == 0; l--) begin
            for (int v = 0; v < 9 && wl == 0; v++) begin
                bit pend = 1'b0;
                int lv;
                for (int s = 0; s < 16; s++) if (src_map[s] == v && src_req[s]) pend = 1'b1;
                if (pend && vec_en[v]) begin
                    lv = !lvl_hi[v] ? 1 : (v < 2 ? 3 : 2);
                    if (lv == l) begin
                        wl = l;
                        wi = v;
                    end
                end
            end
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_lvl = 0;
            model_stk.delete();
        end else begin
            int wl, wi;
            pick(wl, wi);
            if (reti_i) begin
                if (model_stk.size() > 0) model_lvl = model_stk.pop_back();
            end else if (ack_i && wl > model_lvl) begin
                model_stk.push_back(model_lvl);
                model_lvl = wl;
            end
        end
    end

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int wl, wi;
        pick(wl, wi);
        check("irq", int'(irq_o), (wl > model_lvl) ? 1 : 0);
        check("vec_addr", int'(vec_addr_o), (wl > model_lvl) ? 8 * wi + 3 : 0);
        check("cur_lvl", int'(cur_lvl_o), model_lvl);
    end

    task automatic drive(input logic [15:0] s, input logic [8:0] e, input logic [8:0] h,
                         input logic a, input logic r);
        @(posedge clk);
        #1;
        src_req = s;
        vec_en  = e;
        lvl_hi  = h;
        ack_i   = a;
        reti_i  = r;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        // R1: reset state
        tag = "R1";
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        drive('0, '0, '0, 0, 0);

        // R2: each source alone lands on its vector
        tag = "R2";
        for (int s = 0; s < 16; s++) drive(16'(1 << s), '1, '1, 0, 0);

        // R3: disabled vectors ignored
        tag = "R3";
        drive(16'h0001, 9'h1FE, '1, 0, 0);
        drive(16'h0009, 9'h1FE, '1, 0, 0);
        drive(16'hFFFF, 9'h000, '1, 1, 0);

        // R4, R5: level classes and tie order
        tag = "R4";
        drive(16'hFFFF, '1, 9'h000, 0, 0);
        drive(16'hFFFF, '1, 9'h020, 0, 0);
        drive(16'hFFFF, '1, 9'h180, 0, 0);
        tag = "R5";
        drive(16'hFFFF, '1, 9'h022, 0, 0);
        drive(16'hE000, '1, 9'h000, 0, 0);
        drive(16'h1800, '1, 9'h1FF, 0, 0);

        // R7, R6, R11: nest low -> high -> top
        tag = "R7";
        drive(16'h8000, '1, '0, 1, 0);
        tag = "R6";
        drive(16'h8000, '1, '0, 1, 0);
        tag = "R11";
        drive(16'h0080, '1, 9'h008, 1, 0);
        tag = "R6";
        drive(16'h0200, '1, 9'h010, 1, 0);
        tag = "R11";
        drive(16'h0001, '1, 9'h001, 1, 0);
        drive(16'hFFFF, '1, '1, 0, 0);

        // R10: ack and return together
        tag = "R10";
        drive(16'hFFFF, '1, '1, 1, 1);
        drive(16'h0000, '1, '1, 0, 0);

        // R9, R11: unwind and over-return
        tag = "R9";
        drive('0, '1, '1, 0, 1);
        drive('0, '1, '1, 0, 1);
        drive('0, '1, '1, 0, 1);
        drive('0, '1, '1, 0, 0);

        // R8: acknowledge with nothing offered
        tag = "R8";
        drive('0, '1, '1, 1, 0);
        drive(16'h0004, '0, '1, 1, 0);

        // mixed random traffic
        tag = "R11";
        for (int n = 0; n < 4000; n++) begin
            drive(16'($urandom & $urandom & $urandom), 9'($urandom), 9'($urandom),
                  ($urandom % 3) == 0, ($urandom % 5) == 0);
        end
        drive('0, '0, '0, 0, 0);
        @(posedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule